// File: doc/BRIEF.md
# Dual-Channel Serial DAC Code Loader

This block is the digital front end of a two-channel 12-bit converter. A host writes both channel codes as one 24-bit word over three wires: a serial clock, a data line and an active-low select whose rising edge is also the load strobe. The select line, the serial clock and the data line are all brought into a faster system clock domain through two-flop synchronizers. All edge detection then takes place on those synchronized copies. The system clock must run at least eight times faster than the serial clock.

The serial clock is gated internally by the select line, so the shift register only moves while the select line is low. If the serial clock is already high when the select line falls, the gated clock rises at that moment and one extra bit is shifted in. When the select line rises, both parallel codes take their new values in the same system cycle, and a one-cycle update pulse marks that load. The last stage of the shift register is driven out on a serial output, so several of these blocks can be chained, data output to data input, and all of them updated by one shared strobe.

An active-low clear input forces both codes to zero at once, without waiting for a clock edge. While it is held low, it also blocks any load. The clear does not touch the shift register or the serial output, so a frame that is being shifted in while the clear is low still arrives intact.

Top module: `dual_dac_serial_if`

## Requirements
- R1: After system reset, both codes are zero, the serial output is 0 and the update pulse is low.
- R2: Each rising edge of the synchronized serial clock shifts the synchronized data bit into the 24-bit shift register, but only while the select line is low. A complete frame is 24 such edges.
- R3: On load, channel A takes the first 12 bits shifted in and channel B takes the last 12. Within each channel the first bit received becomes bit 11 (MSB first). In register terms, channel A gets shift-register bits 23:12 and channel B gets bits 11:0.
- R4: While the select line is high, serial clock edges shift nothing. The serial output and both codes keep their values.
- R5: A rising edge of the synchronized select line loads both codes in the same system cycle. update_o is high for exactly that one cycle. The codes change at no other time, except through a clear.
- R6: The serial output always shows shift-register bit 23 and changes only after a shifting edge. Before any bit of a new frame has been shifted, it therefore shows the channel-A MSB of the previous frame.
- R7: While clr_ni is low, both codes read zero immediately. No load happens and update_o stays low, even if the select line rises during the clear.
- R8: The clear leaves the shift register and the serial output as they were. A later load with zero shifting edges delivers the bits held in the shift register from before the clear.
- R9: If the serial clock is high when the select line falls, exactly one extra bit is shifted in: the value on the data line at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous system reset (power-on) |
| clr_ni | input | 1 | Active-low asynchronous clear of both codes |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, captured on the serial clock's rising edge |
| csld_ni | input | 1 | Active-low select; its rising edge loads both codes |
| sdo_o | output | 1 | Last shift-register stage, for chaining |
| code_a_o | output | 12 | Channel A code |
| code_b_o | output | 12 | Channel B code |
| update_o | output | 1 | One-cycle pulse when the codes load |

## Verification
A missed or extra shift shows up first on the serial output: after the next synchronized serial edge, about three system cycles after the pin toggles, it no longer matches the bit the frame predicts. A misplaced field boundary or bit order shows up only when the strobe rises, as wrong codes on both channels in the same cycle as the update pulse. A clear that leaks into the shift register shows up only on the following load, as codes that differ from the bits shifted in before the clear.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    // Default geometry of the loader
    localparam int DACIF_CODE_W  = 12;
    localparam int DACIF_NUM_CH  = 2;
    localparam int DACIF_SYNC_N  = 2;
    localparam int DACIF_FRAME_W = DACIF_CODE_W * DACIF_NUM_CH;

    // Bit order of the synchronized pin bundle
    localparam int PIN_CS   = 0;
    localparam int PIN_SDI  = 1;
    localparam int PIN_SCLK = 2;
    localparam int PIN_W    = 3;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdi_s,
    input  logic               cs_s,
    output logic [FRAME_W-1:0] frame_o,
    output logic               sdo_o,
    output logic               load_o
);
    typedef struct packed {
        logic               gclk;   // gated serial clock, previous cycle
        logic               cs;     // select line, previous cycle
        logic [FRAME_W-1:0] sr;     // shift register
    } shf_state_t;

    shf_state_t st_d, st_q;
    logic       gclk_now;

    always_comb begin
        st_d     = st_q;
        gclk_now = sclk_s & ~cs_s;
        st_d.gclk = gclk_now;
        st_d.cs   = cs_s;
        if (gclk_now && !st_q.gclk) begin
            st_d.sr = {st_q.sr[FRAME_W-2:0], sdi_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{gclk: 1'b0, cs: 1'b1, sr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_o = st_q.sr;
    assign sdo_o   = st_q.sr[FRAME_W-1];
    assign load_o  = cs_s & ~st_q.cs;
endmodule

// File: rtl/dacif_chanregs.sv
module dacif_chanregs #(
    parameter int CODE_W = 12,
    parameter int NUM_CH = 2,
    localparam int FRAME_W = CODE_W * NUM_CH
) (
    input  logic                           clk,
    input  logic                           arst_n,
    input  logic                           load_i,
    input  logic [FRAME_W-1:0]             frame_i,
    output logic [NUM_CH-1:0][CODE_W-1:0]  code_o,
    output logic                           upd_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] code;
        logic                          upd;
    } ch_state_t;

    ch_state_t                     st_d, st_q;
    logic [NUM_CH-1:0][CODE_W-1:0] field;

    // Channel 0 owns the bits shifted in first (top of the frame)
    for (genvar g = 0; g < NUM_CH; g++) begin : g_field
        assign field[g] = frame_i[(NUM_CH-g)*CODE_W-1 -: CODE_W];
    end

    always_comb begin
        st_d     = st_q;
        st_d.upd = load_i;
        if (load_i) begin
            st_d.code = field;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign upd_o  = st_q.upd;
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if
    import dacif_pkg::*;
#(
    parameter int CODE_W = DACIF_CODE_W,
    parameter int SYNC_N = DACIF_SYNC_N,
    localparam int NUM_CH  = DACIF_NUM_CH,
    localparam int FRAME_W = CODE_W * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_ni,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              csld_ni,
    output logic              sdo_o,
    output logic [CODE_W-1:0] code_a_o,
    output logic [CODE_W-1:0] code_b_o,
    output logic              update_o
);
    logic [PIN_W-1:0]              pins_raw, pins_s;
    logic                          sclk_s, sdi_s, cs_s;
    logic [FRAME_W-1:0]            frame;
    logic                          load;
    logic                          chan_arst_n;
    logic [NUM_CH-1:0][CODE_W-1:0] codes;

    localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(1) << PIN_CS;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_CS]   = csld_ni;
        pins_raw[PIN_SDI]  = sdi_i;
        pins_raw[PIN_SCLK] = sclk_i;
    end

    dacif_sync #(.W(PIN_W), .STAGES(SYNC_N), .RST_VAL(PIN_RST)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    assign cs_s   = pins_s[PIN_CS];
    assign sdi_s  = pins_s[PIN_SDI];
    assign sclk_s = pins_s[PIN_SCLK];

    dacif_shifter #(.FRAME_W(FRAME_W)) i_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .sdi_s   (sdi_s),
        .cs_s    (cs_s),
        .frame_o (frame),
        .sdo_o   (sdo_o),
        .load_o  (load)
    );

    // Clear reaches the channel registers only
    assign chan_arst_n = rst_n & clr_ni;

    dacif_chanregs #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) i_chanregs (
        .clk     (clk),
        .arst_n  (chan_arst_n),
        .load_i  (load),
        .frame_i (frame),
        .code_o  (codes),
        .upd_o   (update_o)
    );

    assign code_a_o = codes[0];
    assign code_b_o = codes[1];
endmodule

// File: rtl/dacif_checker.sv
module dacif_checker #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_ni,
    input logic              cs_sync,
    input logic              sdo_o,
    input logic [CODE_W-1:0] code_a_o,
    input logic [CODE_W-1:0] code_b_o,
    input logic              update_o
);
    // R5: the update flag lasts one cycle
    assert_update_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    // R5: codes move only together with the update flag, outside a clear
    assert_codes_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ni && $past(clr_ni) && !update_o) |-> ($stable(code_a_o) && $stable(code_b_o)));

    // R7: a held clear shows zero on both channels
    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_ni |-> (code_a_o == '0 && code_b_o == '0));

    // R7: no load is reported during a clear
    assert_clear_no_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_ni |-> !update_o);

    // R4: with the select high, the serial output cannot move
    assert_sdo_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_sync) |-> $stable(sdo_o));
endmodule

bind dual_dac_serial_if dacif_checker #(.CODE_W(CODE_W)) i_dacif_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_ni   (clr_ni),
    .cs_sync  (cs_s),
    .sdo_o    (sdo_o),
    .code_a_o (code_a_o),
    .code_b_o (code_b_o),
    .update_o (update_o)
);

// File: tb/test_dual_dac_serial_if.sv
module test_dual_dac_serial_if;
    localparam int HALF = 6;    // system cycles per serial half period
    localparam int NVEC = 6;
    localparam logic [23:0] VEC [NVEC] = '{
        24'hFFF000, 24'h000FFF, 24'h800001,
        24'hA5C35A, 24'h123ABC, 24'hFFFFFF
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_ni = 1'b1;
    logic        sclk_i = 1'b0;
    logic        sdi_i = 1'b0;
    logic        csld_ni = 1'b1;
    logic        sdo_o;
    logic [11:0] code_a_o, code_b_o;
    logic        update_o;

    int          total = 0;
    int          bad = 0;
    int          upd_cnt = 0;
    bit          done = 1'b0;
    logic [23:0] m_sr = '0;

    always #2 clk = ~clk;   // 250 MHz

    dual_dac_serial_if i_dual_dac_serial_if (
        .clk(clk), .rst_n(rst_n), .clr_ni(clr_ni), .sclk_i(sclk_i),
        .sdi_i(sdi_i), .csld_ni(csld_ni), .sdo_o(sdo_o),
        .code_a_o(code_a_o), .code_b_o(code_b_o), .update_o(update_o)
    );

    always @(negedge clk) if (update_o === 1'b1) upd_cnt++;

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_sys(int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial clock period; checks the serial output after the rise
    task automatic clk_bit(logic b, string tag);
        sdi_i = b;
        wait_sys(HALF);
        sclk_i = 1'b1;
        if (!csld_ni) m_sr = {m_sr[22:0], b};
        wait_sys(HALF);
        chk(sdo_o === m_sr[23], tag, 32'(sdo_o), 32'(m_sr[23]));
        sclk_i = 1'b0;
    endtask

    task automatic open_frame();
        csld_ni = 1'b0;
        wait_sys(HALF);
    endtask

    task automatic close_frame();
        csld_ni = 1'b1;
        wait_sys(HALF);
    endtask

    task automatic send_bits(logic [23:0] w, int nbits);
        for (int i = nbits - 1; i >= 0; i--) clk_bit(w[i], "R2/R6 sdo after edge");
    endtask

    initial begin
        int u0;
        wait_sys(5);
        rst_n = 1'b1;
        wait_sys(4);

        // R1: reset state
        chk(code_a_o === 12'h0 && code_b_o === 12'h0, "R1 codes after reset",
            32'({code_a_o, code_b_o}), 32'h0);
        chk(sdo_o === 1'b0, "R1 sdo after reset", 32'(sdo_o), 32'h0);
        chk(update_o === 1'b0 && upd_cnt == 0, "R1 update idle", 32'(upd_cnt), 32'h0);

        // Table of frames: R2, R3, R5, R6
        for (int v = 0; v < NVEC; v++) begin
            u0 = upd_cnt;
            open_frame();
            chk(sdo_o === m_sr[23], "R6 sdo shows previous A MSB", 32'(sdo_o), 32'(m_sr[23]));
            send_bits(VEC[v], 24);
            close_frame();
            chk(code_a_o === VEC[v][23:12], "R3 channel A code", 32'(code_a_o), 32'(VEC[v][23:12]));
            chk(code_b_o === VEC[v][11:0], "R3 channel B code", 32'(code_b_o), 32'(VEC[v][11:0]));
            chk(upd_cnt == u0 + 1, "R5 one update per load", 32'(upd_cnt), 32'(u0 + 1));
        end

        // R4: serial clock ignored while select is high
        u0 = upd_cnt;
        for (int i = 0; i < 5; i++) clk_bit(i[0], "R4 sdo frozen while deselected");
        chk(code_a_o === 12'hFFF && code_b_o === 12'hFFF, "R4 codes unchanged",
            32'({code_a_o, code_b_o}), 32'hFFFFFF);
        chk(upd_cnt == u0, "R4 no update", 32'(upd_cnt), 32'(u0));
        sdi_i = 1'b0;
        open_frame();
        close_frame();
        chk(code_a_o === 12'hFFF && code_b_o === 12'hFFF, "R4 shift register untouched",
            32'({code_a_o, code_b_o}), 32'hFFFFFF);

        // R7/R8: clear in the middle of a frame
        open_frame();
        send_bits(24'h3C7E19 >> 12, 12);
        clr_ni = 1'b0;
        wait_sys(2);
        chk(code_a_o === 12'h0 && code_b_o === 12'h0, "R7 clear zeroes codes",
            32'({code_a_o, code_b_o}), 32'h0);
        chk(sdo_o === m_sr[23], "R8 sdo kept during clear", 32'(sdo_o), 32'(m_sr[23]));
        clr_ni = 1'b1;
        wait_sys(2);
        send_bits(24'h3C7E19, 12);
        u0 = upd_cnt;
        close_frame();
        chk({code_a_o, code_b_o} === 24'h3C7E19, "R8 frame survives clear",
            32'({code_a_o, code_b_o}), 32'h3C7E19);
        chk(upd_cnt == u0 + 1, "R5 update after clear", 32'(upd_cnt), 32'(u0 + 1));

        // R7/R8: strobe rises while clear is held
        open_frame();
        send_bits(24'h5A55A5, 24);
        clr_ni = 1'b0;
        wait_sys(2);
        u0 = upd_cnt;
        close_frame();
        chk({code_a_o, code_b_o} === 24'h0, "R7 load blocked by clear",
            32'({code_a_o, code_b_o}), 32'h0);
        chk(upd_cnt == u0, "R7 no update during clear", 32'(upd_cnt), 32'(u0));
        clr_ni = 1'b1;
        wait_sys(3);
        chk({code_a_o, code_b_o} === 24'h0, "R7 codes stay zero after release",
            32'({code_a_o, code_b_o}), 32'h0);
        open_frame();
        close_frame();
        chk({code_a_o, code_b_o} === 24'h5A55A5, "R8 reload of kept frame",
            32'({code_a_o, code_b_o}), 32'h5A55A5);

        // R9: select falls while serial clock is high
        sdi_i = 1'b1;
        sclk_i = 1'b1;
        wait_sys(HALF);
        csld_ni = 1'b0;
        m_sr = {m_sr[22:0], 1'b1};
        wait_sys(HALF);
        chk(sdo_o === m_sr[23], "R9 extra shift seen on sdo", 32'(sdo_o), 32'(m_sr[23]));
        sclk_i = 1'b0;
        send_bits(24'h0F0F0F, 23);
        close_frame();
        chk(code_a_o === 12'h8F0, "R9 channel A with extra bit", 32'(code_a_o), 32'h8F0);
        chk(code_b_o === 12'hF0F, "R9 channel B with extra bit", 32'(code_b_o), 32'hF0F);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1..: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule